// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire management bus. It lets an external controller read and write a bank of fifteen 8-bit configuration registers that steer the rest of a clock controller. The controller picks the transfer type with a command byte that follows the device address. With bit 7 of that byte set, one register is reached at an offset. With bit 7 clear, a block transfer runs from offset 0 upwards and carries a byte count.

The bus lines are oversampled by the block's own clock. Both lines pass through synchronizers before START, STOP and clock edges are decoded. The slave only ever pulls SDA low, through an output-enable pin, and changes that pin only while SCL is low. Every register value leaves the block on a flat bus. Two locations are not ordinary storage: offset 0 holds five strap levels in its low bits, and offset 7 holds a constant identification byte. The interface has no link to the state of the clock outputs, so it keeps working while those outputs are powered down.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x69 (first byte 0xD2 for write, 0xD3 for read). For any other address it leaves SDA released for the rest of that transfer and changes no register.
- R2: The write sequence address(W), command, data does a single-register write when command bit 7 is 1. Command bits 6:0 give the offset, and the slave acknowledges every byte.
- R3: The read sequence address(W), command (bit 7 = 1, offset in 6:0), repeated START, address(R) returns the register at that offset.
- R4: The write sequence address(W), command 0x00, count, data0, data1, ... writes the data bytes to offsets 0, 1, 2 and upwards. The count byte is acknowledged and does not limit the transfer. A STOP after any whole byte keeps the bytes already written and leaves the other registers unchanged.
- R5: The read sequence address(W), command 0x00, repeated START, address(R) returns the byte count 15 first, then the registers from offset 0 upwards. A not-acknowledge from the master ends the read.
- R6: Every byte in both directions travels most significant bit first.
- R7: After reset, offsets 0..14 hold 0x40, 0x7F, 0x00, 0xFF, 0x47, 0xDF, 0x03, 0x48, 0x60, 0x1C, 0x0F, 0x00, 0x00, 0x00, 0x00 (offset i on cfg_q[8i+7:8i]). Offset 0 bits 4:0 follow R8.
- R8: Offset 0 bits 4:0 always show strap_fs[4:0], and offset 7 always reads 0x48. Writes to these bits are acknowledged and discarded.
- R9: Writes to offsets above 14 are acknowledged and discarded. Reads from those offsets return 0x00.
- R10: The slave drives SDA low only while SCL is low. It releases SDA after STOP and after START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_fs | input | 5 | Latched frequency-select strap levels |
| cfg_q | output | 120 | Register values, offset i on bits 8i+7:8i |

## Verification
The bench first sends a foreign address followed by a data byte. A slave that decodes the address badly would acknowledge it or would let that byte write a register. It writes all ones to offset 0 and zeros to offset 7, and writes to offset 0x20, so that a missing read-only mask or a missing range check shows up as a corrupted strap field, a corrupted identification byte or a wrapped index. A block write is cut short after three data bytes. A pointer that also advanced on the count byte would shift every value by one offset. A full block read checks the leading count of 15, the ascending order and the release of SDA on the master's not-acknowledge.

// File: rtl/smb_cfg_pkg.sv
`timescale 1ns/1ps
package smb_cfg_pkg;

  localparam int unsigned STRAP_IDX = 0;
  localparam int unsigned ID_IDX    = 7;
  localparam int unsigned STRAP_W   = 5;

  typedef enum logic [2:0] {
    L_IDLE, L_RX, L_RX_ACK, L_TX, L_TX_ACK, L_WAIT
  } link_st_e;

  typedef enum logic [1:0] {
    B_ADDR, B_CMD, B_COUNT, B_DATA
  } byte_role_e;

  // Power-on value per offset
  function automatic logic [7:0] reg_default(input int unsigned idx);
    logic [7:0] v;
    case (idx)
      0:       v = 8'h40;
      1:       v = 8'h7F;
      3:       v = 8'hFF;
      4:       v = 8'h47;
      5:       v = 8'hDF;
      6:       v = 8'h03;
      7:       v = 8'h48;
      8:       v = 8'h60;
      9:       v = 8'h1C;
      10:      v = 8'h0F;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  // Bits that the bus may not change
  function automatic logic [7:0] ro_mask(input int unsigned idx);
    logic [7:0] m;
    if (idx == STRAP_IDX)   m = 8'h1F;
    else if (idx == ID_IDX) m = 8'hFF;
    else                    m = 8'h00;
    return m;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [1:0] raw;
  logic [1:0] lvl;
  logic       scl_d;
  logic       sda_d;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  assign scl_s = lvl[1];
  assign sda_s = lvl[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_regbank.sv
`timescale 1ns/1ps
module smb_regbank
  import smb_cfg_pkg::*;
#(
  parameter int         NUM_REGS = 15,
  parameter logic [7:0] ID_VALUE = 8'h48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [6:0]            idx,
  input  logic [7:0]            wdata,
  input  logic [STRAP_W-1:0]    strap,
  output logic [7:0]            rdata,
  output logic [NUM_REGS*8-1:0] cfg_q
);

  localparam int IW = $clog2(NUM_REGS);

  logic [7:0] view [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RO = ro_mask(g);
    logic [7:0] store;
    logic [7:0] store_n;
    logic [7:0] fixed;
    logic       hit;

    if (g == STRAP_IDX) begin : g_strap
      assign fixed = {{(8-STRAP_W){1'b0}}, strap};
    end else if (g == ID_IDX) begin : g_id
      assign fixed = ID_VALUE;
    end else begin : g_plain
      assign fixed = 8'h00;
    end

    assign hit = we && (idx == 7'(g));

    always_comb begin
      store_n = store;
      if (hit) store_n = (wdata & ~RO) | (store & RO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) store <= reg_default(g);
      else        store <= store_n;
    end

    assign view[g]          = (store & ~RO) | (fixed & RO);
    assign cfg_q[g*8 +: 8]  = view[g];
  end

  assign rdata = (idx < 7'(NUM_REGS)) ? view[idx[IW-1:0]] : 8'h00;

endmodule

// File: rtl/smb_link.sv
`timescale 1ns/1ps
module smb_link
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] BLOCK_LEN = 8'd15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic       reg_we,
  output logic [6:0] reg_idx,
  output logic [7:0] reg_wdata,
  output logic       sda_oe
);

  link_st_e   st, st_n;
  byte_role_e role, role_n;
  logic [7:0] sh, sh_n;
  logic [3:0] bc, bc_n;
  logic [6:0] ptr, ptr_n;
  logic       blk, blk_n;
  logic       rw, rw_n;
  logic       cp, cp_n;
  logic       oe_n;
  logic [7:0] ld_byte;

  // Byte to present when a read byte begins: count first, then registers
  assign ld_byte = cp ? BLOCK_LEN : rd_data;

  always_comb begin
    st_n   = st;
    role_n = role;
    sh_n   = sh;
    bc_n   = bc;
    ptr_n  = ptr;
    blk_n  = blk;
    rw_n   = rw;
    cp_n   = cp;
    oe_n   = sda_oe;
    reg_we = 1'b0;
    if (start_ev) begin
      st_n   = L_RX;
      role_n = B_ADDR;
      bc_n   = 4'd0;
      oe_n   = 1'b0;
    end else if (stop_ev) begin
      st_n = L_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st)
        L_RX: begin
          if (scl_rise && bc < 4'd8) begin
            sh_n = {sh[6:0], sda_s};
            bc_n = bc + 4'd1;
          end else if (scl_fall && bc == 4'd8) begin
            st_n = L_RX_ACK;
            oe_n = 1'b1;
            case (role)
              B_ADDR: begin
                if (sh[7:1] != DEV_ADDR) begin
                  st_n = L_WAIT;
                  oe_n = 1'b0;
                end else begin
                  rw_n   = sh[0];
                  cp_n   = sh[0] & blk;
                  role_n = B_CMD;
                end
              end
              B_CMD: begin
                blk_n  = ~sh[7];
                ptr_n  = sh[7] ? sh[6:0] : 7'd0;
                role_n = sh[7] ? B_DATA : B_COUNT;
              end
              B_COUNT: role_n = B_DATA;
              default: begin
                reg_we = 1'b1;
                ptr_n  = ptr + 7'd1;
              end
            endcase
          end
        end
        L_RX_ACK: begin
          if (scl_fall) begin
            bc_n = 4'd0;
            if (rw) begin
              st_n = L_TX;
              sh_n = ld_byte;
              oe_n = ~ld_byte[7];
              if (cp) cp_n = 1'b0;
              else    ptr_n = ptr + 7'd1;
            end else begin
              st_n = L_RX;
              oe_n = 1'b0;
            end
          end
        end
        L_TX: begin
          if (scl_rise) begin
            bc_n = bc + 4'd1;
          end else if (scl_fall) begin
            if (bc == 4'd8) begin
              st_n = L_TX_ACK;
              oe_n = 1'b0;
            end else begin
              sh_n = {sh[6:0], 1'b0};
              oe_n = ~sh[6];
            end
          end
        end
        L_TX_ACK: begin
          if (scl_rise && sda_s) begin
            st_n = L_WAIT;
          end else if (scl_fall) begin
            st_n = L_TX;
            bc_n = 4'd0;
            sh_n = ld_byte;
            oe_n = ~ld_byte[7];
            if (cp) cp_n = 1'b0;
            else    ptr_n = ptr + 7'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= L_IDLE;
      role   <= B_ADDR;
      sh     <= 8'h00;
      bc     <= 4'd0;
      ptr    <= 7'd0;
      blk    <= 1'b0;
      rw     <= 1'b0;
      cp     <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      st     <= st_n;
      role   <= role_n;
      sh     <= sh_n;
      bc     <= bc_n;
      ptr    <= ptr_n;
      blk    <= blk_n;
      rw     <= rw_n;
      cp     <= cp_n;
      sda_oe <= oe_n;
    end
  end

  assign reg_idx   = ptr;
  assign reg_wdata = sh;

endmodule

// File: rtl/smb_cfg_slave.sv
`timescale 1ns/1ps
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 15,
  parameter logic [7:0] ID_VALUE    = 8'h48,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [STRAP_W-1:0]    strap_fs,
  output logic [NUM_REGS*8-1:0] cfg_q
);

  localparam logic [7:0] BLOCK_LEN = 8'(NUM_REGS);

  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic       reg_we;
  logic [6:0] reg_idx;
  logic [7:0] reg_wdata, rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_link #(.DEV_ADDR(DEV_ADDR), .BLOCK_LEN(BLOCK_LEN)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .sda_oe(sda_oe)
  );

  smb_regbank #(.NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
    .strap(strap_fs), .rdata(rd_data), .cfg_q(cfg_q)
  );

endmodule

// File: rtl/smb_cfg_slave_chk.sv
`timescale 1ns/1ps
module smb_cfg_slave_chk #(
  parameter int NUM_REGS = 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  scl_fall,
  input logic                  start_ev,
  input logic                  stop_ev,
  input logic                  sda_oe,
  input logic                  reg_we,
  input logic [6:0]            reg_idx,
  input logic [NUM_REGS*8-1:0] cfg_q
);

  // R10: the pull-down only begins while SCL is low
  a_r10_drive_onset_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !scl_s);

  // R10: STOP releases the line
  a_r10_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_ev) |-> !sda_oe);

  // R10: START releases the line
  a_r10_release_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_ev) |-> !sda_oe);

  // R2/R4: a register write lands only on the SCL fall that closes a byte
  a_r4_write_on_byte_edge: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> scl_fall);

  // R9: a write beyond the bank leaves every stored bit unchanged
  a_r9_oor_write_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_idx >= 7'(NUM_REGS)) |=>
      (cfg_q[NUM_REGS*8-1:8] == $past(cfg_q[NUM_REGS*8-1:8])) &&
      (cfg_q[7:5] == $past(cfg_q[7:5])));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_idx(reg_idx), .cfg_q(cfg_q)
);

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;

  localparam int NREG = 15;
  localparam int HP   = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             scl_m = 1'b1;
  logic             sda_m = 1'b1;
  logic             sda_oe;
  logic [4:0]       strap = 5'b10110;
  logic [NREG*8-1:0] cfg_q;
  logic             sda_bus;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_reg [NREG];
  logic       done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  smb_cfg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .strap_fs(strap), .cfg_q(cfg_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ro_bits(input int idx);
    if (idx == 0) return 8'h1F;
    if (idx == 7) return 8'hFF;
    return 8'h00;
  endfunction

  // Bench model of a register write, per R8 and R9
  task automatic model_write(input int idx, input logic [7:0] v);
    if (idx < NREG) exp_reg[idx] = (v & ~ro_bits(idx)) | (exp_reg[idx] & ro_bits(idx));
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NREG; i++) chk(req, cfg_q[i*8 +: 8], exp_reg[i]);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wcyc(HP);
    scl_m = 1'b1; wcyc(HP);
    sda_m = 1'b0; wcyc(HP);
    scl_m = 1'b0; wcyc(HP);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wcyc(HP);
    scl_m = 1'b1; wcyc(HP);
    sda_m = 1'b1; wcyc(HP);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wcyc(HP);
      scl_m = 1'b1; wcyc(HP);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wcyc(HP);
    scl_m = 1'b1; wcyc(HP/2);
    nack = sda_bus;
    wcyc(HP/2);
    scl_m = 1'b0; wcyc(HP);
  endtask

  task automatic get_byte(input logic last, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wcyc(HP);
      scl_m = 1'b1; wcyc(HP/2);
      b[i] = sda_bus;
      wcyc(HP/2);
      scl_m = 1'b0;
    end
    wcyc(HP/2);
    sda_m = last; wcyc(HP/2);
    scl_m = 1'b1; wcyc(HP);
    scl_m = 1'b0; wcyc(HP);
    sda_m = 1'b1;
  endtask

  task automatic byte_wr(input string req, input logic [6:0] off, input logic [7:0] v);
    logic n;
    bus_start();
    put_byte(8'hD2, n);        chk({req, " addr ack"}, n, 1'b0);
    put_byte({1'b1, off}, n);  chk({req, " cmd ack"}, n, 1'b0);
    put_byte(v, n);            chk({req, " data ack"}, n, 1'b0);
    bus_stop();
    model_write(int'(off), v);
  endtask

  task automatic byte_rd(input logic [6:0] off, output logic [7:0] v);
    logic n;
    bus_start();
    put_byte(8'hD2, n);
    put_byte({1'b1, off}, n);
    bus_start();
    put_byte(8'hD3, n);
    get_byte(1'b1, v);
    bus_stop();
  endtask

  task automatic t_reset();
    exp_reg = '{8'h40, 8'h7F, 8'h00, 8'hFF, 8'h47, 8'hDF, 8'h03, 8'h48,
                8'h60, 8'h1C, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00};
    exp_reg[0] = 8'h40 | {3'b000, strap};
    check_bank("R7 reset value");
    chk("R10 idle release", sda_oe, 1'b0);
  endtask

  task automatic t_foreign_addr();
    logic n;
    bus_start();
    put_byte({7'h70, 1'b0}, n); chk("R1 foreign address not acked", n, 1'b1);
    put_byte(8'h83, n);         chk("R1 later byte not acked", n, 1'b1);
    put_byte(8'h00, n);
    bus_stop();
    check_bank("R1 bank untouched");
  endtask

  task automatic t_byte_write();
    byte_wr("R2", 7'd3, 8'h5A);
    check_bank("R2 byte write");
    byte_wr("R2", 7'd12, 8'hC3);
    check_bank("R2 byte write high offset");
  endtask

  task automatic t_byte_read();
    logic [7:0] v;
    byte_rd(7'd3, v);  chk("R3 read offset 3", v, 8'h5A);
    byte_rd(7'd12, v); chk("R6 msb-first read offset 12", v, 8'hC3);
    byte_rd(7'd9, v);  chk("R3 read default offset 9", v, 8'h1C);
  endtask

  task automatic t_readonly();
    logic [7:0] v;
    byte_wr("R8", 7'd0, 8'hFF);
    byte_wr("R8", 7'd7, 8'h00);
    check_bank("R8 read-only bits kept");
    byte_rd(7'd7, v); chk("R8 id byte", v, 8'h48);
    byte_rd(7'd0, v); chk("R8 strap field", v, 8'hF6);
  endtask

  task automatic t_out_of_range();
    logic [7:0] v;
    byte_wr("R9", 7'h20, 8'h33);
    check_bank("R9 write discarded");
    byte_rd(7'h20, v); chk("R9 read beyond bank", v, 8'h00);
  endtask

  task automatic t_block_write();
    logic n;
    bus_start();
    put_byte(8'hD2, n); chk("R4 addr ack", n, 1'b0);
    put_byte(8'h00, n); chk("R4 cmd ack", n, 1'b0);
    put_byte(8'h0F, n); chk("R4 count ack", n, 1'b0);
    put_byte(8'hA1, n); chk("R4 data0 ack", n, 1'b0);
    put_byte(8'h12, n);
    put_byte(8'h34, n); chk("R4 data2 ack", n, 1'b0);
    bus_stop();
    model_write(0, 8'hA1);
    model_write(1, 8'h12);
    model_write(2, 8'h34);
    check_bank("R4 partial block write");
    chk("R10 released after stop", sda_oe, 1'b0);
  endtask

  task automatic t_block_read();
    logic n;
    logic [7:0] v;
    bus_start();
    put_byte(8'hD2, n);
    put_byte(8'h00, n);
    bus_start();
    put_byte(8'hD3, n); chk("R5 read addr ack", n, 1'b0);
    get_byte(1'b0, v);  chk("R5 byte count", v, 8'd15);
    for (int i = 0; i < NREG; i++) begin
      get_byte(i == NREG-1, v);
      chk("R5 block data", v, exp_reg[i]);
    end
    wcyc(HP);
    chk("R5 release after nack", sda_oe, 1'b0);
    bus_stop();
  endtask

  initial begin
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    t_reset();
    t_foreign_addr();
    t_byte_write();
    t_byte_read();
    t_readonly();
    t_out_of_range();
    t_block_write();
    t_block_read();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule